// File: doc/BRIEF.md
# Serial Channel Modem Control and Status

This block holds the two modem-facing registers of one serial channel. The control register is written by the CPU. Its low bits drive the active-low terminal-ready and request-to-send outputs, and they gate the output enable of the channel interrupt line. The status register shows the live, synchronized level of four modem inputs (clear-to-send, data-set-ready, ring indicator and carrier detect). Beside each level it keeps a sticky change flag, and the CPU clears the flags by reading the register.

Clear-to-send, data-set-ready and carrier detect flag any change of level. The ring indicator flags only its trailing edge, where the asserted level returns to idle. When any flag is set and the external modem-status interrupt enable is high, the block raises an interrupt request. A change detected in the same clock edge that completes a status read is kept for the next read.

Top module: `mcs_top`

## Requirements
- R1: Writing the control register with bit 0 set drives `dtr_n` low from the next clock edge. Writing it with bit 0 clear drives `dtr_n` high.
- R2: Control bit 1 drives `rts_n` low when set and high when clear, from the clock edge of the write.
- R3: Control bit 3 set drives `irq_oe` high (the interrupt output is enabled). When the bit is clear, `irq_oe` is low.
- R4: While `rst_n` is low, the control register reads 0x00, `dtr_n` and `rts_n` are high, `irq_oe` is low, all change flags are clear and `msi_req` is low.
- R5: Status bits 7:4 show carrier detect (bit 7), ring indicator (bit 6), data-set-ready (bit 5) and clear-to-send (bit 4). Each bit is 1 when its input is 1, and it follows its input two clock edges after the input changes.
- R6: Status bits 0, 1 and 3 are set on any level change of clear-to-send, data-set-ready and carrier detect respectively. Each flag is visible three clock edges after the input change.
- R7: Status bit 2 is set only when the ring indicator goes from 1 to 0. A 0-to-1 change sets no flag.
- R8: A read of the status register returns the flags as they were before the read, then clears them at that clock edge. A change detected at that same edge stays set.
- R9: `msi_req` is high exactly when `msi_en` is high and at least one of status bits 3:0 is set.
- R10: The control register reads back bits 4:0 as written, with bits 7:5 reading 0. Writes to the status register address, or to any address other than the control address (default 4; status default 6), change no register. Reads of unmapped addresses return 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| cpu_sel | input | 1 | Channel select for a CPU access |
| cpu_wr | input | 1 | Write strobe, one cycle per write |
| cpu_rd | input | 1 | Read strobe; a status read clears flags at its clock edge |
| cpu_addr | input | ADDR_W | Register address |
| cpu_wdata | input | DATA_W | Write data |
| cpu_rdata | output | DATA_W | Read data, combinational while `cpu_sel` and `cpu_rd` are high |
| m_cts | input | 1 | Clear-to-send level, asynchronous |
| m_dsr | input | 1 | Data-set-ready level, asynchronous |
| m_ri | input | 1 | Ring indicator level, asynchronous |
| m_dcd | input | 1 | Carrier detect level, asynchronous |
| msi_en | input | 1 | Modem-status interrupt enable |
| dtr_n | output | 1 | Terminal ready, active low |
| rts_n | output | 1 | Request to send, active low |
| irq_oe | output | 1 | Channel interrupt output enable |
| msi_req | output | 1 | Modem-status interrupt request |

## Verification
Control outputs change at the clock edge that completes a write, so the bench checks them at the following falling edge. Status levels appear two edges after an input change, and flags and `msi_req` three edges after. In random stimulus the bench waits four cycles after each input change before it compares, so the model needs no intermediate timing. One directed walk reads the status register at every falling edge after a single input change. This shows the level at the second edge and the flag at the third, with the flag surviving a read that completes on that same edge. Read data is combinational, so it is sampled shortly after the strobes are applied at a falling edge, before the edge that clears the flags.

// File: rtl/mcs_pkg.sv
`timescale 1ns/1ps
package mcs_pkg;
   // modem line indices; status levels sit at NMOD+index, flags at index
   localparam int NMOD   = 4;
   localparam int MI_CTS = 0;
   localparam int MI_DSR = 1;
   localparam int MI_RI  = 2;
   localparam int MI_DCD = 3;

   // control register fields
   localparam int CB_DTR = 0;
   localparam int CB_RTS = 1;
   localparam int CB_IOE = 3;
   localparam int CTRL_W = 5;

   // which lines flag only a 1->0 transition
   localparam logic [NMOD-1:0] FALL_ONLY_MASK = 4'b0100;

   typedef struct packed {
      logic [NMOD-1:0] level;
      logic [NMOD-1:0] flag;
   } stat_word_t;
endpackage

// File: rtl/mcs_sync.sv
`timescale 1ns/1ps
module mcs_sync #(
   parameter int W      = 4,
   parameter int STAGES = 2
) (
   input  logic         clk,
   input  logic         rst_n,
   input  logic [W-1:0] d,
   output logic [W-1:0] q
);
   logic [W-1:0] stg [STAGES];

   generate
      for (genvar s = 0; s < STAGES; s++) begin : g_stage
         if (s == 0) begin : g_first
            always_ff @(posedge clk or negedge rst_n) begin
               if (!rst_n) stg[s] <= '0;
               else        stg[s] <= d;
            end
         end else begin : g_next
            always_ff @(posedge clk or negedge rst_n) begin
               if (!rst_n) stg[s] <= '0;
               else        stg[s] <= stg[s-1];
            end
         end
      end
   endgenerate

   assign q = stg[STAGES-1];
endmodule

// File: rtl/mcs_delta.sv
`timescale 1ns/1ps
module mcs_delta #(
   parameter int              N         = 4,
   parameter logic [N-1:0]    FALL_ONLY = '0
) (
   input  logic         clk,
   input  logic         rst_n,
   input  logic [N-1:0] now,
   input  logic         clr,
   output logic [N-1:0] prev,
   output logic [N-1:0] det,
   output logic [N-1:0] flag
);
   generate
      for (genvar i = 0; i < N; i++) begin : g_line
         if (FALL_ONLY[i]) begin : g_fall
            assign det[i] = prev[i] & ~now[i];
         end else begin : g_any
            assign det[i] = prev[i] ^ now[i];
         end

         always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n) begin
               prev[i] <= 1'b0;
               flag[i] <= 1'b0;
            end else begin
               prev[i] <= now[i];
               // a detection on the clearing edge wins over the clear
               flag[i] <= (flag[i] & ~clr) | det[i];
            end
         end
      end
   endgenerate
endmodule

// File: rtl/mcs_ctrl.sv
`timescale 1ns/1ps
module mcs_ctrl import mcs_pkg::*; #(
   parameter int DATA_W = 8
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              we,
   input  logic [DATA_W-1:0] wdata,
   output logic [DATA_W-1:0] ctrl_q,
   output logic              dtr_n,
   output logic              rts_n,
   output logic              irq_oe
);
   localparam logic [DATA_W-1:0] KEEP_MASK = DATA_W'((1 << CTRL_W) - 1);

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)  ctrl_q <= '0;
      else if (we) ctrl_q <= wdata & KEEP_MASK;
   end

   assign dtr_n  = ~ctrl_q[CB_DTR];
   assign rts_n  = ~ctrl_q[CB_RTS];
   assign irq_oe =  ctrl_q[CB_IOE];
endmodule

// File: rtl/mcs_top.sv
`timescale 1ns/1ps
module mcs_top import mcs_pkg::*; #(
   parameter int                ADDR_W      = 3,
   parameter int                DATA_W      = 8,
   parameter int                SYNC_STAGES = 2,
   parameter logic [ADDR_W-1:0] CTRL_ADDR   = 4,
   parameter logic [ADDR_W-1:0] STAT_ADDR   = 6
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              cpu_sel,
   input  logic              cpu_wr,
   input  logic              cpu_rd,
   input  logic [ADDR_W-1:0] cpu_addr,
   input  logic [DATA_W-1:0] cpu_wdata,
   output logic [DATA_W-1:0] cpu_rdata,
   input  logic              m_cts,
   input  logic              m_dsr,
   input  logic              m_ri,
   input  logic              m_dcd,
   input  logic              msi_en,
   output logic              dtr_n,
   output logic              rts_n,
   output logic              irq_oe,
   output logic              msi_req
);
   localparam int STAT_W = $bits(stat_word_t);

   generate
      if (SYNC_STAGES < 2) begin : g_bad_sync
         $error("SYNC_STAGES must be at least 2");
      end
      if (DATA_W < STAT_W) begin : g_bad_width
         $error("DATA_W too narrow for the status word");
      end
      if (CTRL_ADDR == STAT_ADDR) begin : g_bad_addr
         $error("control and status addresses collide");
      end
   endgenerate

   logic [NMOD-1:0]   pins;
   logic [NMOD-1:0]   st_now;
   logic [NMOD-1:0]   st_prev;
   logic [NMOD-1:0]   det_v;
   logic [NMOD-1:0]   flag_v;
   logic [DATA_W-1:0] ctrl_q;
   logic              ctrl_we;
   logic              stat_rd;
   stat_word_t        stat_w;

   always_comb begin
      pins         = '0;
      pins[MI_CTS] = m_cts;
      pins[MI_DSR] = m_dsr;
      pins[MI_RI]  = m_ri;
      pins[MI_DCD] = m_dcd;
   end

   assign ctrl_we = cpu_sel & cpu_wr & (cpu_addr == CTRL_ADDR);
   assign stat_rd = cpu_sel & cpu_rd & (cpu_addr == STAT_ADDR);

   mcs_sync #(.W(NMOD), .STAGES(SYNC_STAGES)) u_sync (
      .clk   (clk),
      .rst_n (rst_n),
      .d     (pins),
      .q     (st_now)
   );

   mcs_delta #(.N(NMOD), .FALL_ONLY(FALL_ONLY_MASK)) u_delta (
      .clk   (clk),
      .rst_n (rst_n),
      .now   (st_now),
      .clr   (stat_rd),
      .prev  (st_prev),
      .det   (det_v),
      .flag  (flag_v)
   );

   mcs_ctrl #(.DATA_W(DATA_W)) u_ctrl (
      .clk    (clk),
      .rst_n  (rst_n),
      .we     (ctrl_we),
      .wdata  (cpu_wdata),
      .ctrl_q (ctrl_q),
      .dtr_n  (dtr_n),
      .rts_n  (rts_n),
      .irq_oe (irq_oe)
   );

   assign stat_w.level = st_now;
   assign stat_w.flag  = flag_v;

   always_comb begin
      cpu_rdata = '0;
      if (cpu_sel && cpu_rd) begin
         if (cpu_addr == CTRL_ADDR)      cpu_rdata = ctrl_q;
         else if (cpu_addr == STAT_ADDR) cpu_rdata[STAT_W-1:0] = stat_w;
      end
   end

   assign msi_req = msi_en & (|flag_v);
endmodule

// File: rtl/mcs_chk.sv
`timescale 1ns/1ps
module mcs_chk #(
   parameter int                ADDR_W    = 3,
   parameter logic [ADDR_W-1:0] CTRL_ADDR = 4,
   parameter logic [ADDR_W-1:0] STAT_ADDR = 6
) (
   input logic              clk,
   input logic              rst_n,
   input logic              cpu_sel,
   input logic              cpu_wr,
   input logic              cpu_rd,
   input logic [ADDR_W-1:0] cpu_addr,
   input logic [2:0]        wbits,
   input logic              dtr_n,
   input logic              rts_n,
   input logic              irq_oe,
   input logic              msi_en,
   input logic              msi_req,
   input logic [3:0]        st_prev,
   input logic [3:0]        det_v,
   input logic [3:0]        flag_v
);
   logic wr_hit;
   logic rd_hit;
   assign wr_hit = cpu_sel & cpu_wr & (cpu_addr == CTRL_ADDR);
   assign rd_hit = cpu_sel & cpu_rd & (cpu_addr == STAT_ADDR);

   // R1
   dtr_follow_chk: assert property (@(posedge clk) disable iff (!rst_n)
      wr_hit |=> (dtr_n == !$past(wbits[0])));
   // R2
   rts_follow_chk: assert property (@(posedge clk) disable iff (!rst_n)
      wr_hit |=> (rts_n == !$past(wbits[1])));
   // R3
   ioe_follow_chk: assert property (@(posedge clk) disable iff (!rst_n)
      wr_hit |=> (irq_oe == $past(wbits[2])));
   // R4
   reset_idle_chk: assert property (@(posedge clk)
      !rst_n |=> (dtr_n && rts_n && !irq_oe && !msi_req));
   // R6
   cts_flag_cause_chk: assert property (@(posedge clk) disable iff (!rst_n)
      $rose(flag_v[0]) |-> (st_prev[0] != $past(st_prev[0])));
   // R6
   dsr_flag_cause_chk: assert property (@(posedge clk) disable iff (!rst_n)
      $rose(flag_v[1]) |-> (st_prev[1] != $past(st_prev[1])));
   // R6
   dcd_flag_cause_chk: assert property (@(posedge clk) disable iff (!rst_n)
      $rose(flag_v[3]) |-> (st_prev[3] != $past(st_prev[3])));
   // R7
   ri_fall_only_chk: assert property (@(posedge clk) disable iff (!rst_n)
      $rose(flag_v[2]) |-> (!st_prev[2] && $past(st_prev[2])));
   // R8
   read_clears_chk: assert property (@(posedge clk) disable iff (!rst_n)
      rd_hit |=> ((flag_v & ~$past(det_v)) == 4'b0000));
   // R9
   req_gated_chk: assert property (@(posedge clk) disable iff (!rst_n)
      msi_req |-> (msi_en && (flag_v != 4'b0000)));
endmodule

bind mcs_top mcs_chk #(
   .ADDR_W    (ADDR_W),
   .CTRL_ADDR (CTRL_ADDR),
   .STAT_ADDR (STAT_ADDR)
) u_chk (
   .clk     (clk),
   .rst_n   (rst_n),
   .cpu_sel (cpu_sel),
   .cpu_wr  (cpu_wr),
   .cpu_rd  (cpu_rd),
   .cpu_addr(cpu_addr),
   .wbits   ({cpu_wdata[3], cpu_wdata[1], cpu_wdata[0]}),
   .dtr_n   (dtr_n),
   .rts_n   (rts_n),
   .irq_oe  (irq_oe),
   .msi_en  (msi_en),
   .msi_req (msi_req),
   .st_prev (st_prev),
   .det_v   (det_v),
   .flag_v  (flag_v)
);

// File: tb/sim_mcs_top.sv
`timescale 1ns/1ps
module sim_mcs_top;
   localparam logic [2:0] A_CTRL = 3'd4;
   localparam logic [2:0] A_STAT = 3'd6;

   logic       clk = 1'b0;
   logic       rst_n = 1'b0;
   logic       cpu_sel = 1'b0, cpu_wr = 1'b0, cpu_rd = 1'b0;
   logic [2:0] cpu_addr = '0;
   logic [7:0] cpu_wdata = '0;
   logic [7:0] cpu_rdata;
   logic       m_cts = 1'b0, m_dsr = 1'b0, m_ri = 1'b0, m_dcd = 1'b0;
   logic       msi_en = 1'b0;
   logic       dtr_n, rts_n, irq_oe, msi_req;

   int  n_cmp = 0;
   int  n_bad = 0;
   bit  done  = 0;

   logic [3:0] m_pins  = 4'b0000;   // {dcd, ri, dsr, cts}
   logic [3:0] m_flags = 4'b0000;
   logic [7:0] m_ctrl  = 8'h00;

   always #10 clk = ~clk;

   mcs_top u0 (
      .clk(clk), .rst_n(rst_n), .cpu_sel(cpu_sel), .cpu_wr(cpu_wr), .cpu_rd(cpu_rd),
      .cpu_addr(cpu_addr), .cpu_wdata(cpu_wdata), .cpu_rdata(cpu_rdata),
      .m_cts(m_cts), .m_dsr(m_dsr), .m_ri(m_ri), .m_dcd(m_dcd), .msi_en(msi_en),
      .dtr_n(dtr_n), .rts_n(rts_n), .irq_oe(irq_oe), .msi_req(msi_req)
   );

   function automatic logic [3:0] next_flags(input logic [3:0] old_p, input logic [3:0] new_p,
                                             input logic [3:0] fl);
      return fl | ((old_p ^ new_p) & 4'b1011) | (old_p & ~new_p & 4'b0100);
   endfunction

   function automatic logic [7:0] stat_word(input logic [3:0] p, input logic [3:0] fl);
      return {p, fl};
   endfunction

   task automatic chk(input string req, input logic [7:0] act, input logic [7:0] exp);
      n_cmp++;
      if (act !== exp) begin
         n_bad++;
         $display("FAIL %s: actual %02h expected %02h", req, act, exp);
      end
   endtask

   task automatic tick(input int n);
      repeat (n) @(negedge clk);
   endtask

   task automatic wr(input logic [2:0] a, input logic [7:0] d);
      cpu_sel = 1'b1; cpu_wr = 1'b1; cpu_addr = a; cpu_wdata = d;
      @(negedge clk);
      cpu_sel = 1'b0; cpu_wr = 1'b0;
   endtask

   task automatic rd(input logic [2:0] a, output logic [7:0] d);
      cpu_sel = 1'b1; cpu_rd = 1'b1; cpu_addr = a;
      #2 d = cpu_rdata;
      @(negedge clk);
      cpu_sel = 1'b0; cpu_rd = 1'b0;
   endtask

   task automatic set_pins(input logic [3:0] p);
      m_cts = p[0]; m_dsr = p[1]; m_ri = p[2]; m_dcd = p[3];
   endtask

   task automatic check_ctrl_outputs(input string req);
      chk({req, " dtr_n"},  {7'd0, dtr_n},  {7'd0, ~m_ctrl[0]});
      chk({req, " rts_n"},  {7'd0, rts_n},  {7'd0, ~m_ctrl[1]});
      chk({req, " irq_oe"}, {7'd0, irq_oe}, {7'd0,  m_ctrl[3]});
   endtask

   task automatic summary;
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
   endtask

   initial begin
      repeat (100000) @(posedge clk);
      if (!done) begin
         n_cmp++; n_bad++;
         $display("FAIL all: actual hung expected finished");
         summary();
         $finish;
      end
   end

   initial begin
      logic [7:0] d;
      logic [3:0] np;
      void'($urandom(32'h5EED_0042));

      // R4: reset state
      tick(3);
      rd(A_CTRL, d);
      chk("R4 ctrl in reset", d, 8'h00);
      chk("R4 outputs in reset", {4'd0, dtr_n, rts_n, irq_oe, msi_req}, 8'b0000_1100);
      rd(A_STAT, d);
      chk("R4 status in reset", d, 8'h00);
      rst_n = 1'b1;
      tick(2);

      // R1 R2 R3 directed
      wr(A_CTRL, 8'h01); m_ctrl = 8'h01; check_ctrl_outputs("R1 dtr set");
      wr(A_CTRL, 8'h02); m_ctrl = 8'h02; check_ctrl_outputs("R2 rts only");
      wr(A_CTRL, 8'h08); m_ctrl = 8'h08; check_ctrl_outputs("R3 ioe only");
      // R10: readback mask and ignored writes
      wr(A_CTRL, 8'hFF); m_ctrl = 8'h1F;
      rd(A_CTRL, d); chk("R10 ctrl readback mask", d, 8'h1F);
      wr(A_STAT, 8'hFF);
      rd(A_STAT, d); chk("R10 status write ignored", d, 8'h00);
      wr(3'd0, 8'h00);
      rd(A_CTRL, d); chk("R10 other address write ignored", d, 8'h1F);
      check_ctrl_outputs("R10 outputs unchanged");
      rd(3'd1, d); chk("R10 unmapped read", d, 8'h00);

      // R5 R6 R8 R9: timing walk on clear-to-send
      msi_en = 1'b1;
      set_pins(4'b0001);                   // change before edge 1
      tick(1);                             // after edge 1
      rd(A_STAT, d); chk("R5 level not yet after 1 edge", d, 8'h00);
      // now after edge 2; this read completes at edge 3
      chk("R9 no request before flag", {7'd0, msi_req}, 8'h00);
      rd(A_STAT, d); chk("R5 level after 2 edges", d, 8'h10);
      chk("R8 flag kept across same-edge read", {7'd0, msi_req}, 8'h01);
      rd(A_STAT, d); chk("R6 flag after 3 edges", d, 8'h11);
      rd(A_STAT, d); chk("R8 cleared by read", d, 8'h10);
      chk("R9 request drops after clear", {7'd0, msi_req}, 8'h00);
      m_pins = 4'b0001;

      // R7: ring rising sets nothing, falling sets bit 2
      set_pins(4'b0101); tick(4);
      rd(A_STAT, d); chk("R7 ring rise no flag", d, 8'h50);
      set_pins(4'b0001); tick(4);
      rd(A_STAT, d); chk("R7 ring fall flag", d, 8'h14);
      msi_en = 1'b0;
      set_pins(4'b1001); tick(4);
      chk("R9 disabled request low", {7'd0, msi_req}, 8'h00);
      rd(A_STAT, d); chk("R6 carrier flag", d, 8'h98);
      m_pins = 4'b1001; m_flags = 4'b0000;

      // random phase
      for (int it = 0; it < 400; it++) begin
         int unsigned op = $urandom % 8;
         if (op < 4) begin
            np = 4'($urandom);
            set_pins(np);
            msi_en = 1'($urandom);
            tick(4);
            m_flags = next_flags(m_pins, np, m_flags);
            m_pins = np;
            chk("R9 random request", {7'd0, msi_req}, {7'd0, msi_en & (|m_flags)});
         end else if (op < 6) begin
            rd(A_STAT, d);
            chk("R5 R6 R7 R8 random status", d, stat_word(m_pins, m_flags));
            m_flags = 4'b0000;
         end else if (op == 6) begin
            logic [7:0] wv = 8'($urandom);
            wr(A_CTRL, wv); m_ctrl = wv & 8'h1F;
            check_ctrl_outputs("R1 R2 R3 random");
            rd(A_CTRL, d); chk("R10 random readback", d, m_ctrl);
         end else begin
            logic [2:0] a = 3'($urandom);
            if (a != A_CTRL) wr(a, 8'($urandom));
            rd(A_CTRL, d); chk("R10 stray write", d, m_ctrl);
         end
      end

      // R4: reset again clears control and flags
      set_pins(4'b0010); tick(4);
      rst_n = 1'b0;
      tick(1);
      chk("R4 re-reset outputs", {4'd0, dtr_n, rts_n, irq_oe, msi_req}, 8'b0000_1100);
      rd(A_CTRL, d); chk("R4 re-reset ctrl", d, 8'h00);
      set_pins(4'b0000);
      rd(A_STAT, d); chk("R4 re-reset status", d, 8'h00);

      done = 1;
      summary();
      $finish;
   end
endmodule